// File: doc/BRIEF.md
# Satellite Control Bus Tone-Gate Transmitter

This block produces the on/off envelope that keys an external 22 kHz carrier for a satellite equipment control bus. A host places up to six command bytes on a parallel data input, gives a byte count and an optional burst selection, and pulses `start`. The block then drives a single `tone_en` line through the whole transaction. The sequence is a quiet lead-in, the bytes in pulse-width code with one parity bit per byte, a quiet tail, and an optional burst followed by a settle interval. A one-cycle `done` pulse marks the end.

Each bit has a tone-on part followed by a tone-off part. The ratio of the two parts carries the bit value. Every duration is counted in ticks of a 1 us enable input, so the system clock frequency does not change the waveform. When no transaction is running, a static-tone input can hold the carrier on continuously.

Top module: `tonegate_tx`

## Requirements
- R1: A data or parity bit of value 1 is sent as `tone_en` high for T_SHORT ticks, then low for T_LONG ticks.
- R2: A data or parity bit of value 0 is sent as `tone_en` high for T_LONG ticks, then low for T_SHORT ticks.
- R3: Each byte goes out as its 8 data bits, bit 7 first and bit 0 last, then its parity bit. Bytes are sent in order from the lowest slot: slot k occupies `msg_data[8k+7:8k]`.
- R4: The parity bit is 1 XOR all eight data bits, so the nine bits of a byte always hold an odd number of ones.
- R5: `tone_en` stays low for T_GAP ticks before the first byte and for T_GAP ticks after the last byte. An empty message still has both gaps.
- R6: With `burst_req`=1 and `burst_mod`=1, the byte 0xFF and its parity bit are sent after the trailing gap in normal bit coding. `tone_en` then stays low for T_SETTLE ticks.
- R7: With `burst_req`=1 and `burst_mod`=0, `tone_en` is held high for T_BURST ticks after the trailing gap, then low for T_SETTLE ticks.
- R8: While idle, `tone_en` equals `tone_static`. During a transaction `tone_static` has no effect.
- R9: `msg_len` of 0 sends no bytes. The gaps and any requested burst are still sent. Values above MAX_BYTES are treated as MAX_BYTES.
- R10: `busy` rises on the cycle after `start` is taken and falls when the last trailing interval ends. In that same cycle `done` pulses high for exactly one cycle. A `start` seen while busy is ignored and is not remembered.
- R11: Every interval lasts its stated number of `tick_us` pulses, whatever the number of clock cycles between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Begin a transaction (taken only when idle) |
| msg_len | input | $clog2(MAX_BYTES+1) | Number of bytes to send |
| msg_data | input | MAX_BYTES*8 | Byte slots, slot 0 in the low byte |
| burst_req | input | 1 | Append a burst after the message |
| burst_mod | input | 1 | 1: modulated 0xFF burst, 0: solid tone burst |
| tone_static | input | 1 | Hold carrier on while idle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| tone_en | output | 1 | Carrier gate |

## Verification
Most internal faults show up at `tone_en` within one bit time. A wrong phase or a bad duration load shifts an edge by whole ticks. A wrong shift or parity state flips the ratio of the on and off parts of a single bit. A stuck byte or burst index instead adds or removes complete nine-bit groups, or merges a tail gap into a burst. These faults only become visible when the trailing interval ends too early or too late, which can be up to T_GAP plus T_SETTLE ticks after the fault. For this reason every transaction is compared against an independently built run-length list of the whole envelope, and the bench also watches the `busy`/`done` handshake.

// File: rtl/tonegate_pkg.sv
package tonegate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HI,
    ST_LO,
    ST_POST,
    ST_BURST,
    ST_SETTLE
  } tg_state_t;

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/tg_tick_timer.sv
module tg_tick_timer #(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire,
  output logic [TW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expire = tick && (count == TW'(1));

endmodule

// File: rtl/tg_bit_shifter.sv
module tg_bit_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       adv,
  output logic       cur_bit,
  output logic       nxt_bit,
  output logic       last_bit,
  output logic [3:0] bit_cnt
);

  logic [7:0] sr;
  logic       par;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      par     <= 1'b1;
      bit_cnt <= '0;
    end else if (load) begin
      sr      <= load_byte;
      par     <= ~(^load_byte);
      bit_cnt <= '0;
    end else if (adv) begin
      sr      <= {sr[6:0], 1'b0};
      bit_cnt <= bit_cnt + 4'd1;
    end
  end

  assign last_bit = (bit_cnt == 4'd8);
  assign cur_bit  = last_bit ? par : sr[7];
  assign nxt_bit  = (bit_cnt < 4'd7) ? sr[6] : par;

endmodule

// File: rtl/tg_msg_store.sv
module tg_msg_store #(
  parameter int NB = 6,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [NB*8-1:0] wdata,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_byte
);

  logic [7:0] mem [NB];

  for (genvar g = 0; g < NB; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we) mem[g] <= wdata[g*8 +: 8];
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (int'(rd_idx) == i) rd_byte = mem[i];
    end
  end

endmodule

// File: rtl/tonegate_tx.sv
module tonegate_tx
  import tonegate_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int T_SHORT   = 500,
  parameter int T_LONG    = 1000,
  parameter int T_GAP     = 16000,
  parameter int T_BURST   = 12500,
  parameter int T_SETTLE  = 20000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_us,
  input  logic                   start,
  input  logic [$clog2(MAX_BYTES+1)-1:0] msg_len,
  input  logic [MAX_BYTES*8-1:0] msg_data,
  input  logic                   burst_req,
  input  logic                   burst_mod,
  input  logic                   tone_static,
  output logic                   busy,
  output logic                   done,
  output logic                   tone_en
);

  localparam int LW   = $clog2(MAX_BYTES + 1);
  localparam int IW   = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int MAXD = int'(max5(T_SHORT, T_LONG, T_GAP, T_BURST, T_SETTLE));
  localparam int TW   = $clog2(MAXD + 1);

  localparam logic [TW-1:0] D_SHORT  = TW'(T_SHORT);
  localparam logic [TW-1:0] D_LONG   = TW'(T_LONG);
  localparam logic [TW-1:0] D_GAP    = TW'(T_GAP);
  localparam logic [TW-1:0] D_BURST  = TW'(T_BURST);
  localparam logic [TW-1:0] D_SETTLE = TW'(T_SETTLE);
  localparam logic [LW-1:0] LEN_MAX  = LW'(MAX_BYTES);

  tg_state_t       state, state_n;
  logic [IW-1:0]   byte_idx, byte_idx_n;
  logic [LW-1:0]   nbytes_q;
  logic            burst_q, mod_q;
  logic            in_burst, in_burst_n;
  logic            finish;

  logic            tmr_load, tmr_exp;
  logic [TW-1:0]   tmr_val, tmr_cnt;
  logic            shf_load, shf_adv, load_ff;
  logic            cur_bit, nxt_bit, last_bit;
  logic [3:0]      bit_cnt;
  logic [IW-1:0]   rd_idx;
  logic [7:0]      rd_byte;
  logic            take;

  assign take = (state == ST_IDLE) && start;

  tg_tick_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .load(tmr_load),
    .load_val(tmr_val), .expire(tmr_exp), .count(tmr_cnt)
  );

  tg_bit_shifter u_shift (
    .clk(clk), .rst(rst), .load(shf_load),
    .load_byte(load_ff ? 8'hFF : rd_byte), .adv(shf_adv),
    .cur_bit(cur_bit), .nxt_bit(nxt_bit), .last_bit(last_bit), .bit_cnt(bit_cnt)
  );

  tg_msg_store #(.NB(MAX_BYTES), .IW(IW)) u_store (
    .clk(clk), .we(take), .wdata(msg_data), .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  assign rd_idx = (state == ST_PRE) ? '0 : IW'(byte_idx + 1'b1);

  always_comb begin
    state_n    = state;
    byte_idx_n = byte_idx;
    in_burst_n = in_burst;
    tmr_load   = 1'b0;
    tmr_val    = D_GAP;
    shf_load   = 1'b0;
    shf_adv    = 1'b0;
    load_ff    = 1'b0;
    finish     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_n    = ST_PRE;
          tmr_load   = 1'b1;
          tmr_val    = D_GAP;
          byte_idx_n = '0;
          in_burst_n = 1'b0;
        end
      end
      ST_PRE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (nbytes_q != '0) begin
            shf_load   = 1'b1;
            byte_idx_n = '0;
            state_n    = ST_HI;
            tmr_val    = rd_byte[7] ? D_SHORT : D_LONG;
          end else begin
            state_n = ST_POST;
            tmr_val = D_GAP;
          end
        end
      end
      ST_HI: begin
        if (tmr_exp) begin
          state_n  = ST_LO;
          tmr_load = 1'b1;
          tmr_val  = cur_bit ? D_LONG : D_SHORT;
        end
      end
      ST_LO: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (!last_bit) begin
            shf_adv = 1'b1;
            state_n = ST_HI;
            tmr_val = nxt_bit ? D_SHORT : D_LONG;
          end else if (in_burst) begin
            state_n = ST_SETTLE;
            tmr_val = D_SETTLE;
          end else if ((int'(byte_idx) + 1) < int'(nbytes_q)) begin
            shf_load   = 1'b1;
            byte_idx_n = IW'(byte_idx + 1'b1);
            state_n    = ST_HI;
            tmr_val    = rd_byte[7] ? D_SHORT : D_LONG;
          end else begin
            state_n = ST_POST;
            tmr_val = D_GAP;
          end
        end
      end
      ST_POST: begin
        if (tmr_exp) begin
          if (!burst_q) begin
            finish  = 1'b1;
            state_n = ST_IDLE;
          end else if (mod_q) begin
            tmr_load   = 1'b1;
            shf_load   = 1'b1;
            load_ff    = 1'b1;
            in_burst_n = 1'b1;
            state_n    = ST_HI;
            tmr_val    = D_SHORT;
          end else begin
            tmr_load = 1'b1;
            state_n  = ST_BURST;
            tmr_val  = D_BURST;
          end
        end
      end
      ST_BURST: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          state_n  = ST_SETTLE;
          tmr_val  = D_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          finish  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      in_burst <= 1'b0;
      nbytes_q <= '0;
      burst_q  <= 1'b0;
      mod_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      tone_en  <= 1'b0;
    end else begin
      state    <= state_n;
      byte_idx <= byte_idx_n;
      in_burst <= in_burst_n;
      if (take) begin
        nbytes_q <= (msg_len > LEN_MAX) ? LEN_MAX : msg_len;
        burst_q  <= burst_req;
        mod_q    <= burst_mod;
      end
      busy    <= (state_n != ST_IDLE);
      done    <= finish;
      tone_en <= (state_n == ST_HI) || (state_n == ST_BURST) ||
                 ((state_n == ST_IDLE) && tone_static);
    end
  end

endmodule

// File: rtl/tonegate_tx_chk.sv
module tonegate_tx_chk #(
  parameter int TW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_us,
  input logic          tone_static,
  input logic          busy,
  input logic          done,
  input logic          tone_en,
  input logic          tmr_load,
  input logic [TW-1:0] tmr_cnt,
  input logic [3:0]    bit_cnt
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_end_signals_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_idle_static_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !busy) |-> (tone_en == $past(tone_static)));

  assert_lead_gap_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tone_en);

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick_us && !tmr_load) |=> $stable(tmr_cnt));

  assert_bit_range_R3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 4'd8);

endmodule

bind tonegate_tx tonegate_tx_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .tick_us(tick_us), .tone_static(tone_static),
  .busy(busy), .done(done), .tone_en(tone_en), .tmr_load(tmr_load),
  .tmr_cnt(tmr_cnt), .bit_cnt(bit_cnt)
);

// File: tb/tb_tonegate_tx.sv
module tb_tonegate_tx;

  localparam int CLK_PERIOD = 10;
  localparam int MB  = 6;
  localparam int LW  = $clog2(MB + 1);
  localparam int TS  = 4;
  localparam int TL  = 8;
  localparam int TG  = 20;
  localparam int TB  = 30;
  localparam int TST = 25;

  logic clk = 1'b0;
  logic rst;
  logic tick_us;
  logic start;
  logic [LW-1:0] msg_len;
  logic [MB*8-1:0] msg_data;
  logic burst_req, burst_mod, tone_static;
  logic busy, done, tone_en;

  int nchk = 0;
  int nbad = 0;
  int tp   = 1;
  int tdiv = 0;

  int exp_lvl [0:255];
  int exp_len [0:255];
  int n_exp;
  int obs_lvl [0:255];
  int obs_len [0:255];
  int n_obs;

  always #(CLK_PERIOD/2) clk = ~clk;

  tonegate_tx #(.MAX_BYTES(MB), .T_SHORT(TS), .T_LONG(TL), .T_GAP(TG),
                .T_BURST(TB), .T_SETTLE(TST)) dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .start(start), .msg_len(msg_len),
    .msg_data(msg_data), .burst_req(burst_req), .burst_mod(burst_mod),
    .tone_static(tone_static), .busy(busy), .done(done), .tone_en(tone_en)
  );

  initial begin
    tick_us = 1'b0;
    forever begin
      @(negedge clk);
      if (tdiv >= tp - 1) begin
        tdiv = 0;
        tick_us = 1'b1;
      end else begin
        tdiv++;
        tick_us = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  task automatic chk(input string tag, input bit ok, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic exp_add(input int lvl, input int t);
    if (n_exp > 0 && exp_lvl[n_exp-1] == lvl) exp_len[n_exp-1] += t;
    else begin
      exp_lvl[n_exp] = lvl;
      exp_len[n_exp] = t;
      n_exp++;
    end
  endtask

  task automatic exp_byte(input logic [7:0] b);
    int p = 1;
    for (int i = 7; i >= 0; i--) begin
      p ^= int'(b[i]);
      exp_add(1, b[i] ? TS : TL);
      exp_add(0, b[i] ? TL : TS);
    end
    exp_add(1, p[0] ? TS : TL);
    exp_add(0, p[0] ? TL : TS);
  endtask

  task automatic build(input int n);
    n_exp = 0;
    exp_add(0, TG);
    for (int k = 0; k < n; k++) exp_byte(msg_data[k*8 +: 8]);
    exp_add(0, TG);
    if (burst_req) begin
      if (burst_mod) exp_byte(8'hFF);
      else exp_add(1, TB);
      exp_add(0, TST);
    end
  endtask

  // Runs one transaction and compares the whole envelope against the expected list.
  task automatic run(input string tag, input int intrude_at);
    int cyc = 0;
    logic st = tone_static;
    do begin
      @(negedge clk);
      #1;
    end while (!tick_us);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_obs = 0;
    while (busy && cyc < 20000) begin
      if (n_obs == 0 || obs_lvl[n_obs-1] != int'(tone_en)) begin
        obs_lvl[n_obs] = int'(tone_en);
        obs_len[n_obs] = 1;
        n_obs++;
      end else obs_len[n_obs-1]++;
      cyc++;
      if (cyc == intrude_at) begin
        start = 1'b1;
        msg_len = 1;
        msg_data = ~msg_data;
        burst_req = ~burst_req;
      end
      if (cyc == intrude_at + 1) start = 1'b0;
      @(negedge clk);
    end
    chk({tag, " segment count"}, n_obs == n_exp, n_obs, n_exp);
    begin
      int bad_i = -1;
      for (int i = 0; i < n_exp && i < n_obs; i++)
        if (bad_i < 0 && (obs_lvl[i] != exp_lvl[i] || obs_len[i] != exp_len[i] * tp)) bad_i = i;
      if (bad_i >= 0)
        chk({tag, " segment length/level"}, 1'b0, obs_len[bad_i] * 2 + obs_lvl[bad_i],
            exp_len[bad_i] * tp * 2 + exp_lvl[bad_i]);
      else chk({tag, " segments"}, 1'b1, 0, 0);
    end
    chk("R10 done at end", done == 1'b1, int'(done), 1);
    chk("R8 idle tone at end", tone_en == st, int'(tone_en), int'(st));
    @(negedge clk);
    chk("R10 done one cycle", done == 1'b0, int'(done), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; msg_len = '0; msg_data = '0;
    burst_req = 1'b0; burst_mod = 1'b0; tone_static = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset busy", busy == 1'b0, int'(busy), 0);
    chk("R10 reset done", done == 1'b0, int'(done), 0);
    chk("R8 reset tone", tone_en == 1'b0, int'(tone_en), 0);
  endtask

  task automatic t_single;
    msg_len = 1; msg_data = '0; msg_data[7:0] = 8'hA5; burst_req = 1'b0;
    build(1);
    run("R1/R2/R3/R5 byte A5", -1);
    msg_data[7:0] = 8'h80;
    build(1);
    run("R1/R2/R3 byte 80", -1);
  endtask

  task automatic t_parity;
    msg_len = 2; msg_data = '0; msg_data[15:0] = 16'h0001;
    build(2);
    run("R4 bytes 01,00", -1);
    msg_data[15:0] = 16'h7F03;
    build(2);
    run("R4 bytes 03,7F", -1);
  endtask

  task automatic t_lengths;
    msg_len = 6; msg_data = 48'h1E_C3_5A_96_0F_F0; burst_req = 1'b0;
    build(6);
    run("R3 six bytes", -1);
    msg_len = 7;
    build(6);
    run("R9 length clamp", -1);
    msg_len = 0;
    build(0);
    run("R9/R5 empty message", -1);
    burst_req = 1'b1; burst_mod = 1'b0;
    build(0);
    run("R9/R7 empty with burst", -1);
  endtask

  task automatic t_bursts;
    msg_len = 2; msg_data = '0; msg_data[15:0] = 16'h33CC;
    burst_req = 1'b1; burst_mod = 1'b1;
    build(2);
    run("R6 modulated burst", -1);
    msg_len = 1; burst_mod = 1'b0;
    build(1);
    run("R7 solid burst", -1);
    burst_req = 1'b0;
  endtask

  task automatic t_static;
    tone_static = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 static idle high", tone_en == 1'b1, int'(tone_en), 1);
    msg_len = 1; msg_data[7:0] = 8'h5A;
    build(1);
    run("R8 static ignored in message", -1);
    tone_static = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 static released", tone_en == 1'b0, int'(tone_en), 0);
  endtask

  task automatic t_busy_start;
    msg_len = 2; msg_data = '0; msg_data[15:0] = 16'h81E7;
    burst_req = 1'b0; burst_mod = 1'b0;
    build(2);
    run("R10 start while busy", 60);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) seen++;
      end
      chk("R10 no deferred start", seen == 0, seen, 0);
    end
    burst_req = 1'b0;
  endtask

  task automatic t_tick_div;
    tp = 3;
    msg_len = 1; msg_data[7:0] = 8'hB2; burst_req = 1'b1; burst_mod = 1'b0;
    build(1);
    run("R11 tick every third clock", -1);
    tp = 2; burst_mod = 1'b1;
    build(1);
    run("R11 tick every second clock", -1);
    tp = 1; burst_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_parity();
    t_lengths();
    t_bursts();
    t_static();
    t_busy_start();
    t_tick_div();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule